// File: doc/BRIEF.md
# Multiphase Buck Start-Up and Protection Supervisor

This block is the digital supervisor of a multiphase buck regulator. Analog comparators, the reference ramp and the PWM modulator live outside it. It sees their results as single-bit flags: supply ready, enable above its high threshold, enable below its low threshold, feedback over-voltage, feedback under-voltage, over-temperature and soft-start done. It also receives the number of phases currently running and a digitized current-monitor value. From these it steps a sequence: wait for supply, wait for enable, a fixed initialization delay, soft-start and regulation. It drives the ramp release, the power-good flag, one latched flag per fault and a two-bit output-stage command for every phase.

Each fault has its own consecutive-sample glitch filter and its own latch. Over-voltage forces the low-side switch on in every active phase. The other faults turn both switches off. The total over-current limit applied to the monitor value follows the active phase count. All pins are plain level signals sampled on the clock. The block has no streaming traffic, so none of its pins use a valid/ready handshake.

Top module: `pss_supervisor`

## Requirements
- R1: While `supply_ok` is low, `ss_go` and `pgood` are low, every stage command is off (code 0) and the fault flags are cleared, whatever `en_hi` does.
- R2: Once the supply is ready, a sampled `en_hi` starts the initialization wait. `ss_go` rises exactly INIT_CYC = CLK_KHZ*11/10 clock edges after the edge that sampled `en_hi`.
- R3: A sampled `en_lo` returns the block to waiting for enable. It clears `pgood` and every fault flag on that edge, and the next `en_hi` runs a complete new start-up.
- R4: During soft-start, `pgood` rises on the edge that samples `ss_done`, with no further delay, unless a fault latches on that edge.
- R5: `pgood` falls on the same edge on which any fault flag sets.
- R6: Over-voltage (flag bit 0) and under-voltage (flag bit 1) latch only after their raw flag has been high for FILT_CYC = CLK_KHZ/200 consecutive edges. A shorter excursion restarts the count and latches nothing.
- R7: With the over-voltage flag set, every active phase is driven with code 2 (low-side on, high-side off).
- R8: With a fault other than over-voltage set, every phase is driven with code 0 (both switches off).
- R9: Total over-current (flag bit 3) trips when `imon_code` (20 mV per LSB) exceeds the limit for the effective phase count. The limits are 1:55, 2:65, 3:80, 4:90, 5:105, 6:120, 7:135, 8:150 codes. The monitor value must stay above the limit for 2 consecutive edges.
- R10: The effective phase count is `phase_cnt`, with 0 treated as 1 and values above NPH treated as NPH. Phases at index at or above it are always driven with code 0. In soft-start and regulation without a fault, active phases use code 1 (switching).
- R11: Fault flags hold until `en_lo` or a supply loss. Faults are watched only during soft-start and regulation; raw flags at other times latch nothing.
- R12: Over-temperature (flag bit 2) latches after its raw flag has been high for 2 consecutive edges during soft-start or regulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Controller supply ready (power-on reset released) |
| en_hi | input | 1 | Enable above its start threshold |
| en_lo | input | 1 | Enable below its stop threshold |
| ov_raw | input | 1 | Feedback above 1.5x reference |
| uv_raw | input | 1 | Feedback below 0.5x reference |
| ot_raw | input | 1 | Die temperature above its limit |
| ss_done | input | 1 | Reference ramp complete and output at target |
| phase_cnt | input | PCW (4) | Number of phases currently running |
| imon_code | input | MON_W (8) | Digitized current monitor, 20 mV per LSB |
| ss_go | output | 1 | Release of the soft-start ramp |
| pgood | output | 1 | Power good |
| fault_flags | output | 4 | Latched faults: bit 0 OV, 1 UV, 2 OT, 3 OC |
| stage_cmd | output | 2*NPH (16) | Per-phase command at bits [2i+1:2i]: 0 off, 1 switching, 2 low-side on |

## Verification
The bench goes after off-by-one errors in the two timers. It checks `ss_go` one edge before and on the edge of release, and an over-voltage pulse one sample shorter than the filter window next to one that exactly fills it. A design that counted one edge too many or too few would release early or trip on the glitch. Over-current is swept across every phase count, including 0 and the counts above NPH. The monitor is held exactly at the limit and then one code above it, so a table that is off by one entry or a `>=` comparison shows up as an early or missing trip. The bench also checks that faults cannot latch outside soft-start and regulation, that they survive the raw flag clearing, and that enable-low and supply loss wipe them. A design that kept a stale latch would show a fault flag or no `pgood` after the next start-up.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_IDLE  = 3'd1,
    ST_INIT  = 3'd2,
    ST_SOFT  = 3'd3,
    ST_REG   = 3'd4,
    ST_FAULT = 3'd5
  } sup_state_e;

  localparam logic [1:0] STG_OFF  = 2'd0;
  localparam logic [1:0] STG_RUN  = 2'd1;
  localparam logic [1:0] STG_LSON = 2'd2;

  localparam int unsigned FI_OV   = 0;
  localparam int unsigned FI_UV   = 1;
  localparam int unsigned FI_OT   = 2;
  localparam int unsigned FI_OC   = 3;
  localparam int unsigned N_FAULT = 4;

  // total current limit in 20 mV codes, indexed by running phase count
  function automatic logic [7:0] ocp_limit_code(input int unsigned n);
    case (n)
      1:       ocp_limit_code = 8'd55;
      2:       ocp_limit_code = 8'd65;
      3:       ocp_limit_code = 8'd80;
      4:       ocp_limit_code = 8'd90;
      5:       ocp_limit_code = 8'd105;
      6:       ocp_limit_code = 8'd120;
      7:       ocp_limit_code = 8'd135;
      default: ocp_limit_code = 8'd150;
    endcase
  endfunction

endpackage

// File: rtl/pss_glitch_filter.sv
module pss_glitch_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic raw,
  output logic trip
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!arm || !raw) begin
      run_cnt <= '0;
    end else if (run_cnt != CW'(LEN - 1)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign trip = arm & raw & (run_cnt == CW'(LEN - 1));
endmodule

// File: rtl/pss_fault_bank.sv
module pss_fault_bank
  import pss_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 250,
  parameter int unsigned SHORT_LEN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               clr,
  input  logic [N_FAULT-1:0] raw,
  output logic               trip_any,
  output logic [N_FAULT-1:0] latched
);
  logic [N_FAULT-1:0] trip;

  for (genvar g = 0; g < N_FAULT; g++) begin : g_filt
    localparam int unsigned FLEN =
      (g == FI_OV || g == FI_UV) ? LONG_LEN : SHORT_LEN;
    pss_glitch_filter #(.LEN(FLEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (arm),
      .raw  (raw[g]),
      .trip (trip[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= '0;
    end else if (clr) begin
      latched <= '0;
    end else begin
      latched <= latched | trip;
    end
  end

  assign trip_any = |trip;
endmodule

// File: rtl/pss_stage_drive.sv
module pss_stage_drive
  import pss_pkg::*;
#(
  parameter int unsigned NPH = 8,
  parameter int unsigned PCW = 4
) (
  input  sup_state_e         st,
  input  logic               ov_hold,
  input  logic [PCW-1:0]     n_act,
  output logic [2*NPH-1:0]   cmd
);
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic [1:0] code;
    always_comb begin
      code = STG_OFF;
      if (PCW'(g) < n_act) begin
        case (st)
          ST_SOFT, ST_REG: code = STG_RUN;
          ST_FAULT:        code = ov_hold ? STG_LSON : STG_OFF;
          default:         code = STG_OFF;
        endcase
      end
    end
    assign cmd[2*g +: 2] = code;
  end
endmodule

// File: rtl/pss_supervisor.sv
module pss_supervisor
  import pss_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned NPH       = 8,
  parameter int unsigned PCW       = 4,
  parameter int unsigned MON_W     = 8,
  parameter int unsigned SHORT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             en_hi,
  input  logic             en_lo,
  input  logic             ov_raw,
  input  logic             uv_raw,
  input  logic             ot_raw,
  input  logic             ss_done,
  input  logic [PCW-1:0]   phase_cnt,
  input  logic [MON_W-1:0] imon_code,
  output logic             ss_go,
  output logic             pgood,
  output logic [3:0]       fault_flags,
  output logic [2*NPH-1:0] stage_cmd
);
  localparam int unsigned INIT_CYC = (CLK_KHZ * 11) / 10;
  localparam int unsigned FILT_CYC = (CLK_KHZ / 200 > 0) ? CLK_KHZ / 200 : 1;
  localparam int unsigned ICW      = $clog2(INIT_CYC + 1);

  sup_state_e        st_q, st_d;
  logic [ICW-1:0]    init_cnt;
  logic [PCW-1:0]    pc_eff;
  logic [7:0]        oc_lim;
  logic              oc_raw;
  logic              arm, clr, trip_any;
  logic [N_FAULT-1:0] raw_vec;

  // effective phase count: 0 reads as one phase, excess saturates
  always_comb begin
    if (phase_cnt == '0)             pc_eff = PCW'(1);
    else if (phase_cnt > PCW'(NPH))  pc_eff = PCW'(NPH);
    else                             pc_eff = phase_cnt;
  end

  assign oc_lim = ocp_limit_code(int'(pc_eff));
  assign oc_raw = imon_code > MON_W'(oc_lim);

  always_comb begin
    raw_vec        = '0;
    raw_vec[FI_OV] = ov_raw;
    raw_vec[FI_UV] = uv_raw;
    raw_vec[FI_OT] = ot_raw;
    raw_vec[FI_OC] = oc_raw;
  end

  assign arm = (st_q == ST_SOFT) || (st_q == ST_REG);
  assign clr = !supply_ok || en_lo;

  pss_fault_bank #(
    .LONG_LEN (FILT_CYC),
    .SHORT_LEN(SHORT_LEN)
  ) u_faults (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .clr     (clr),
    .raw     (raw_vec),
    .trip_any(trip_any),
    .latched (fault_flags)
  );

  always_comb begin
    st_d = st_q;
    if (!supply_ok) begin
      st_d = ST_RESET;
    end else if (en_lo) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_RESET: st_d = ST_IDLE;
        ST_IDLE:  if (en_hi) st_d = ST_INIT;
        ST_INIT:  if (init_cnt == ICW'(INIT_CYC - 1)) st_d = ST_SOFT;
        ST_SOFT: begin
          if (trip_any)     st_d = ST_FAULT;
          else if (ss_done) st_d = ST_REG;
        end
        ST_REG:   if (trip_any) st_d = ST_FAULT;
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RESET;
      init_cnt <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_INIT) init_cnt <= init_cnt + 1'b1;
      else                 init_cnt <= '0;
    end
  end

  assign ss_go = (st_q == ST_SOFT) || (st_q == ST_REG);
  assign pgood = (st_q == ST_REG);

  pss_stage_drive #(
    .NPH(NPH),
    .PCW(PCW)
  ) u_drive (
    .st     (st_q),
    .ov_hold(fault_flags[FI_OV]),
    .n_act  (pc_eff),
    .cmd    (stage_cmd)
  );
endmodule

// File: rtl/pss_supervisor_chk.sv
module pss_supervisor_chk #(
  parameter int unsigned NPH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             en_lo,
  input logic             ss_done,
  input logic             ss_go,
  input logic             pgood,
  input logic [3:0]       fault_flags,
  input logic [2*NPH-1:0] stage_cmd
);
  logic any_run;
  always_comb begin
    any_run = 1'b0;
    for (int i = 0; i < NPH; i++) begin
      if (stage_cmd[2*i +: 2] == 2'd1) any_run = 1'b1;
    end
  end

  assert_supply_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!ss_go && !pgood && fault_flags == 4'd0));

  assert_en_low_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && en_lo) |=> (fault_flags == 4'd0 && !pgood));

  assert_pgood_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(ss_done));

  assert_fault_kills_pgood_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flags != 4'd0) |-> (!pgood && !any_run));

  assert_ov_lowside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flags[0] |-> (stage_cmd[1:0] == 2'd2));

  assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flags != 4'd0 && supply_ok && !en_lo) |=>
      ((fault_flags & $past(fault_flags)) == $past(fault_flags)));
endmodule

bind pss_supervisor pss_supervisor_chk #(.NPH(NPH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .en_lo      (en_lo),
  .ss_done    (ss_done),
  .ss_go      (ss_go),
  .pgood      (pgood),
  .fault_flags(fault_flags),
  .stage_cmd  (stage_cmd)
);

// File: tb/test_pss_supervisor.sv
module test_pss_supervisor;
  localparam int CLK_KHZ = 2000;
  localparam int NPH     = 8;
  localparam int INIT    = CLK_KHZ * 11 / 10;
  localparam int FILT    = CLK_KHZ / 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, en_hi = 1'b0, en_lo = 1'b0;
  logic ov_raw = 1'b0, uv_raw = 1'b0, ot_raw = 1'b0, ss_done = 1'b0;
  logic [3:0] phase_cnt = 4'd8;
  logic [7:0] imon_code = 8'd0;
  logic ss_go, pgood;
  logic [3:0] fault_flags;
  logic [2*NPH-1:0] stage_cmd;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pss_supervisor #(.CLK_KHZ(CLK_KHZ), .NPH(NPH)) i_pss_supervisor (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_hi(en_hi),
    .en_lo(en_lo), .ov_raw(ov_raw), .uv_raw(uv_raw), .ot_raw(ot_raw),
    .ss_done(ss_done), .phase_cnt(phase_cnt), .imon_code(imon_code),
    .ss_go(ss_go), .pgood(pgood), .fault_flags(fault_flags),
    .stage_cmd(stage_cmd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_count(input int pc);
    if (pc == 0) return 1;
    if (pc > NPH) return NPH;
    return pc;
  endfunction

  function automatic int stage_exp(input int eff, input int code);
    int v = 0;
    for (int i = 0; i < NPH; i++) if (i < eff) v = v | (code << (2 * i));
    return v;
  endfunction

  function automatic int limit_mv(input int n);
    case (n)
      1: return 1100; 2: return 1300; 3: return 1600; 4: return 1800;
      5: return 2100; 6: return 2400; 7: return 2700; default: return 3000;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_soft();
    en_hi = 1'b1;
    tick(1);
    en_hi = 1'b0;
    tick(INIT - 1);
    check("R2 ss_go before init ends", ss_go, 0);
    tick(1);
    check("R2 ss_go at init end", ss_go, 1);
    check("R4 pgood low in soft-start", pgood, 0);
  endtask

  task automatic to_reg();
    to_soft();
    ss_done = 1'b1;
    tick(1);
    check("R4 pgood on ss_done", pgood, 1);
    check("R3 fresh start no faults", fault_flags, 0);
  endtask

  task automatic shut();
    en_lo = 1'b1;
    tick(1);
    check("R3 en_lo clears faults", fault_flags, 0);
    check("R3 en_lo drops pgood", pgood, 0);
    en_lo = 1'b0;
    ss_done = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 reset ss_go", ss_go, 0);
    check("R1 reset pgood", pgood, 0);
    check("R1 reset stages", stage_cmd, 0);
    check("R1 reset faults", fault_flags, 0);
    en_hi = 1'b1;
    tick(INIT + 20);
    check("R1 no start without supply", ss_go, 0);
    en_hi = 1'b0;
    supply_ok = 1'b1;
    tick(2);

    // phase masking sweep in regulation (R10)
    to_reg();
    for (int pc = 0; pc < 16; pc++) begin
      phase_cnt = pc[3:0];
      #2;
      check("R10 stage mask", stage_cmd, stage_exp(eff_count(pc), 1));
      tick(1);
    end
    phase_cnt = 4'd8;

    // over-voltage glitch then real trip (R6, R5, R7)
    ov_raw = 1'b1;
    tick(FILT - 1);
    ov_raw = 1'b0;
    tick(1);
    check("R6 short OV ignored", fault_flags, 0);
    check("R6 pgood after glitch", pgood, 1);
    ov_raw = 1'b1;
    tick(FILT - 1);
    check("R6 OV one short of window", fault_flags, 0);
    tick(1);
    check("R6 OV latched at window", fault_flags, 1);
    check("R5 pgood drops with fault", pgood, 0);
    check("R7 OV low-side on", stage_cmd, stage_exp(8, 2));
    ov_raw = 1'b0;
    tick(20);
    check("R11 OV holds", fault_flags, 1);
    phase_cnt = 4'd3;
    #2;
    check("R7 OV low-side active only", stage_cmd, stage_exp(3, 2));
    phase_cnt = 4'd8;
    shut();

    // under-voltage (R6, R8)
    to_reg();
    uv_raw = 1'b1;
    tick(FILT - 1);
    check("R6 UV before window", fault_flags, 0);
    tick(1);
    check("R6 UV latched", fault_flags, 2);
    check("R8 UV all off", stage_cmd, 0);
    uv_raw = 1'b0;
    shut();

    // over-temperature (R12, R8)
    to_reg();
    ot_raw = 1'b1;
    tick(1);
    check("R12 OT after one edge", fault_flags, 0);
    tick(1);
    check("R12 OT latched", fault_flags, 4);
    check("R8 OT all off", stage_cmd, 0);
    ot_raw = 1'b0;
    shut();

    // faults not watched while idle (R11)
    ov_raw = 1'b1; uv_raw = 1'b1; ot_raw = 1'b1; imon_code = 8'd255;
    tick(FILT * 3);
    check("R11 idle ignores faults", fault_flags, 0);
    check("R11 idle stages off", stage_cmd, 0);
    ov_raw = 1'b0; uv_raw = 1'b0; ot_raw = 1'b0; imon_code = 8'd0;

    // fault during soft-start blocks pgood (R5, R11)
    to_soft();
    uv_raw = 1'b1;
    tick(FILT);
    check("R11 UV latched in soft-start", fault_flags, 2);
    uv_raw = 1'b0;
    ss_done = 1'b1;
    tick(2);
    check("R5 no pgood with fault", pgood, 0);
    check("R5 ramp stopped", ss_go, 0);
    shut();

    // over-current limit sweep over phase counts (R9)
    for (int pc = 0; pc < 10; pc++) begin
      int thr;
      phase_cnt = pc[3:0];
      thr = limit_mv(eff_count(pc)) / 20;
      to_reg();
      imon_code = thr[7:0];
      tick(5);
      check("R9 at limit no trip", fault_flags, 0);
      imon_code = 8'(thr + 1);
      tick(1);
      check("R9 one edge above limit", fault_flags, 0);
      tick(1);
      check("R9 OC latched", fault_flags, 8);
      check("R8 OC all off", stage_cmd, 0);
      imon_code = 8'd0;
      shut();
    end
    phase_cnt = 4'd8;

    // supply loss clears latches (R1)
    to_reg();
    ot_raw = 1'b1;
    tick(2);
    check("R12 OT latched before drop", fault_flags, 4);
    ot_raw = 1'b0;
    supply_ok = 1'b0;
    tick(1);
    check("R1 supply loss clears faults", fault_flags, 0);
    check("R1 supply loss ss_go", ss_go, 0);
    check("R1 supply loss stages", stage_cmd, 0);
    supply_ok = 1'b1;
    ss_done = 1'b0;
    tick(2);
    to_reg();
    check("R3 restart after supply", pgood, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule